// File: doc/BRIEF.md
# Register Request Handler for a Serial-Bus Physical Layer

This block sits behind the serial request receiver of a physical-layer device. It accepts register read and write requests after they have been fully decoded. It applies them to a local register file of sixteen 8-bit registers. A write updates its register on the clock edge where the decoded request is presented. A read is not answered at once. The block holds it as the one outstanding read and offers its address and the register contents to the status-transfer serializer through a request/acknowledge handshake. The read stays outstanding until that handshake completes.

While a read is outstanding, any further read request is dropped. Write requests are accepted at any time, including while a bus request is waiting elsewhere or while a status transfer is in flight. A bus reset never discards the outstanding read. It only withdraws an offered transfer, and the transfer is offered again with freshly sampled contents once the bus reset ends. The whole register file is also exported as a flat vector for the rest of the device to decode.

Top module: `phy_regreq_handler`

## Requirements
- R1: After chip reset (`rst_n` low at a clock edge) every register reads 0, `stat_req` is 0 and no read is outstanding.
- R2: A request with `req_valid`=1 and `req_write`=1 writes `req_data` into register `req_addr` at that clock edge. Register n occupies bits [8n+7:8n] of `reg_image`.
- R3: A request with `req_valid`=1 and `req_write`=0, accepted at edge k, raises `stat_req` at edge k+1, provided `bus_reset` is low at that edge. `stat_addr` then holds the requested address, and `stat_data` holds the register contents as they were just before edge k+1.
- R4: While `stat_req` is high, `stat_addr` and `stat_data` stay constant. A write to the same register that lands on or after the edge where `stat_req` rose is not reflected in `stat_data`.
- R5: A read request that arrives while a read is outstanding is ignored, unless it coincides with a completing acknowledge (R9). No later transfer is offered for it.
- R6: `stat_ack`=1 while `stat_req`=1 and `bus_reset`=0 completes the transfer. `stat_req` falls at that edge and the read is no longer outstanding.
- R7: `bus_reset`=1 at an edge drops `stat_req` and ignores `stat_ack`, but keeps the read outstanding. The transfer is offered again at the first edge where `bus_reset` is low.
- R8: A write to the address of an outstanding read whose transfer has not yet started (or was withdrawn by R7) is reflected in the data that transfer returns.
- R9: A read request in the same cycle as a completing acknowledge is accepted. Its transfer is offered one edge later.
- R10: Writes are accepted while a read is outstanding and while a status transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous chip reset, active low |
| req_valid | input | 1 | One-cycle strobe: a decoded register request is complete |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 4 | Register address of the request |
| req_data | input | 8 | Write data (ignored for reads) |
| bus_reset | input | 1 | Bus reset in progress |
| stat_req | output | 1 | Status transfer offered to the serializer |
| stat_addr | output | 4 | Address carried by the status transfer |
| stat_data | output | 8 | Register contents carried by the status transfer |
| stat_ack | input | 1 | Serializer has delivered the status transfer |
| reg_image | output | 128 | All registers, register n at bits [8n+7:8n] |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a completing acknowledge and a new read request. The bench provokes it by pulsing a read on the very cycle `stat_ack` is high, and expects the new address to be offered two edges later rather than being dropped. The second pair is the start of a transfer and a write to the register being read. The bench issues the write exactly on the edge where `stat_req` rises, and expects the old contents in `stat_data` but the new value in `reg_image`. A behavioural reference model judges both pairs on every clock, alongside directed checks.

// File: rtl/phy_regreq_handler.sv
module phy_regreq_handler #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_data,
  input  logic                              bus_reset,
  output logic                              stat_req,
  output logic [ADDR_W-1:0]                 stat_addr,
  output logic [DATA_W-1:0]                 stat_data,
  input  logic                              stat_ack,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     reg_image
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];
  logic              pend;
  logic              busy;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata;

  wire wr      = req_valid && req_write;
  wire done    = busy && stat_ack && !bus_reset;
  wire take_rd = req_valid && !req_write && (!pend || done);
  wire launch  = pend && !busy && !bus_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr) begin
      regs[req_addr] <= req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      busy  <= 1'b0;
      paddr <= '0;
      pdata <= '0;
    end else begin
      if (bus_reset) begin
        busy <= 1'b0;
      end else if (done) begin
        busy <= 1'b0;
        pend <= 1'b0;
      end else if (launch) begin
        busy  <= 1'b1;
        pdata <= regs[paddr];
      end
      if (take_rd) begin
        pend  <= 1'b1;
        paddr <= req_addr;
      end
    end
  end

  assign stat_req  = busy;
  assign stat_addr = paddr;
  assign stat_data = pdata;

  for (genvar g = 0; g < NREG; g++) begin : g_img
    assign reg_image[g*DATA_W +: DATA_W] = regs[g];
  end

  assert_write_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> reg_image[$past(req_addr)*DATA_W +: DATA_W] == $past(req_data));

  assert_offer_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rd && !bus_reset) |=> (pend && (stat_req || !$past(stat_req) || $past(bus_reset) || $past(done))));

  assert_hold_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_req && !stat_ack && !bus_reset) |=> (stat_req && $stable(stat_addr) && $stable(stat_data)));

  assert_ignore_second_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done && req_valid && !req_write) |=> $stable(stat_addr));

  assert_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_req && stat_ack && !bus_reset && !take_rd) |=> (!stat_req && !pend));

  assert_busreset_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && pend) |=> (!stat_req && pend));
endmodule

// File: tb/phy_regreq_handler_test.sv
`timescale 1ns/1ps
module phy_regreq_handler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, bus_reset = 1'b0, stat_ack = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic stat_req;
  logic [3:0] stat_addr;
  logic [7:0] stat_data;
  logic [127:0] reg_image;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phy_regreq_handler uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .bus_reset(bus_reset),
    .stat_req(stat_req), .stat_addr(stat_addr), .stat_data(stat_data),
    .stat_ack(stat_ack), .reg_image(reg_image));

  // behavioural reference model
  logic [7:0] m_regs [16];
  bit m_pend, m_busy;
  logic [3:0] m_addr;
  logic [7:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = 8'h00;
      m_pend = 0; m_busy = 0; m_addr = '0; m_data = '0;
    end else begin
      bit fin, acc, st;
      fin = m_busy && stat_ack && !bus_reset;
      acc = req_valid && !req_write && (!m_pend || fin);
      st  = m_pend && !m_busy && !bus_reset;
      if (bus_reset) m_busy = 0;
      else if (fin) begin m_busy = 0; m_pend = 0; end
      else if (st) begin m_busy = 1; m_data = m_regs[m_addr]; end
      if (acc) begin m_pend = 1; m_addr = req_addr; end
      if (req_valid && req_write) m_regs[req_addr] = req_data;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] m_image();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_regs[i];
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
    chk("R3 R6 model stat_req", stat_req, m_busy);
    if (m_busy) begin
      chk("R3 R4 model stat_addr", stat_addr, m_addr);
      chk("R4 R8 model stat_data", stat_data, m_data);
    end
    chk("R2 R10 model reg_image", reg_image, m_image());
    req_valid = 0; stat_ack = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_data = d;
  endtask

  task automatic rd(input logic [3:0] a);
    req_valid = 1; req_write = 0; req_addr = a; req_data = 8'hEE;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 stat_req after reset", stat_req, 0);
    chk("R1 reg_image after reset", reg_image, 0);
    rst_n = 1;
    tick();

    wr(4'd3, 8'hA5); tick();
    chk("R2 write addr3", reg_image[31:24], 8'hA5);
    wr(4'd15, 8'h3C); tick();
    chk("R2 write addr15", reg_image[127:120], 8'h3C);
    wr(4'd0, 8'hFF); tick();
    chk("R2 write addr0", reg_image[7:0], 8'hFF);

    rd(4'd3); tick();
    chk("R3 not yet offered", stat_req, 0);
    wr(4'd3, 8'h11); tick();
    chk("R3 offered", stat_req, 1);
    chk("R3 addr", stat_addr, 4'd3);
    chk("R4 launch-edge write not seen", stat_data, 8'hA5);
    chk("R10 write during launch", reg_image[31:24], 8'h11);
    rd(4'd15); tick();
    chk("R5 addr unchanged", stat_addr, 4'd3);
    wr(4'd3, 8'h22); tick();
    chk("R4 data held", stat_data, 8'hA5);
    chk("R10 write in flight", reg_image[31:24], 8'h22);
    stat_ack = 1; tick();
    chk("R6 ack drops stat_req", stat_req, 0);
    tick(); tick();
    chk("R5 ignored read never offered", stat_req, 0);

    bus_reset = 1; rd(4'd0); tick();
    wr(4'd0, 8'h42); tick();
    chk("R7 held off in bus reset", stat_req, 0);
    bus_reset = 0; tick();
    chk("R7 offered after bus reset", stat_req, 1);
    chk("R8 fresh data", stat_data, 8'h42);
    bus_reset = 1; stat_ack = 1; tick();
    chk("R7 withdrawn", stat_req, 0);
    bus_reset = 0; wr(4'd0, 8'h43); tick();
    chk("R7 reoffered", stat_req, 1);
    chk("R8 data after withdrawal", stat_data, 8'h42);

    stat_ack = 1; rd(4'd15); tick();
    chk("R9 ack cycle", stat_req, 0);
    tick();
    chk("R9 new read offered", stat_req, 1);
    chk("R9 new addr", stat_addr, 4'd15);
    chk("R9 new data", stat_data, 8'h3C);
    stat_ack = 1; tick();
    chk("R6 second ack", stat_req, 0);

    rd(4'd0); tick(); tick();
    chk("R3 read addr0", stat_data, 8'h43);
    stat_ack = 1; tick(); tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule